// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access-Rights Check

This block caches recent page translations for 4 KB pages. A lookup presents a virtual address and an access kind. The block compares the virtual page number against the tag of every valid entry at once. In the same cycle it returns one of four outcomes:

- **served**: the physical address is formed from the entry's physical page number and the untouched 12-bit page offset.
- **absent**: no valid entry matches.
- **rights violation**: an entry matches but does not allow the access.
- **dirty-update needed**: a store hits a writable page whose dirty flag is still clear, so the translation is not served.

An external table walker answers an absent or dirty-update outcome by sending a refill over a valid/ready channel. The refill is installed as follows:

- If a valid entry already carries the same page number, that entry is overwritten, so a tag never appears twice.
- Otherwise the lowest-numbered empty slot is used.
- Otherwise a replacement victim is used. It comes from a rotating pointer (default) or from a free-running pseudo-random register, selected by a parameter.

A flush pin empties the whole structure in one cycle. It is meant to be pulsed whenever the page-table base changes.

Back-pressure rules: the lookup path takes no back-pressure. A lookup is evaluated in every cycle that `lk_valid` is high, and its outcome is valid only in that cycle. The refill channel transfers in a cycle where `fill_valid` and `fill_ready` are both high. `fill_ready` is low exactly in cycles where `flush` is high. A walker holding `fill_valid` simply waits out the flush, and the refill it offers in that cycle is not taken.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is empty, so every lookup reports absent (`lk_miss`).
- R2: A lookup whose page number matches a valid entry that allows the access raises `lk_hit` in the same cycle, with `lk_paddr` equal to the entry's physical page number joined above the lookup's 12 low address bits.
- R3: A lookup whose page number matches no valid entry raises `lk_miss`, and `lk_paddr` is zero.
- R4: Access code 0 (load) needs the read flag, code 1 (store) needs the write flag, and code 2 (fetch) needs the execute flag. Code 3 always fails. A matching lookup whose check fails raises `lk_fault` and not `lk_hit`.
- R5: A store that matches an entry whose write flag is set and dirty flag is clear raises `lk_dirty` and not `lk_hit`, and `lk_paddr` is zero.
- R6: When `lk_valid` is high exactly one of `lk_hit`, `lk_miss`, `lk_fault`, `lk_dirty` is high. When `lk_valid` is low all four are low.
- R7: A refill accepted in one cycle is visible to lookups from the next cycle on. A lookup in the same cycle as the refill sees the old contents.
- R8: A refill whose page number already sits in a valid entry overwrites that entry, so no tag is ever held twice.
- R9: Otherwise a refill goes to the lowest-numbered empty entry.
- R10: With the rotating policy and no empty entry, the victim is the entry named by a pointer. The pointer starts at 0 after reset and steps by one, wrapping, on every accepted refill.
- R11: `flush` empties every entry at the next clock edge. `fill_ready` is low while `flush` is high, and a refill offered then is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| lk_hit | output | 1 | Translation served |
| lk_miss | output | 1 | No valid entry matches |
| lk_fault | output | 1 | Access rights violated |
| lk_dirty | output | 1 | Store needs dirty flag set first |
| lk_paddr | output | PPN_W+OFF_W | Physical address, zero unless `lk_hit` |
| fill_valid | input | 1 | Refill offered |
| fill_ready | output | 1 | Refill can be accepted |
| fill_vpn | input | VPN_W | Refill page number tag |
| fill_ppn | input | PPN_W | Refill physical page number |
| fill_r | input | 1 | Refill read flag |
| fill_w | input | 1 | Refill write flag |
| fill_x | input | 1 | Refill execute flag |
| fill_d | input | 1 | Refill dirty flag |
| flush | input | 1 | Empty all entries |

## Verification
Lookup outcomes and the physical address depend only on the current inputs and the stored state, so they are due in the same cycle the lookup is driven. Refills and flushes change the stored state at the next rising edge, so their effect is due on lookups from the following cycle. The bench drives all inputs just after a falling edge and compares every output with its reference model one time unit later. It advances the model only after the rising edge that commits the refill or flush. A same-cycle refill-and-lookup of one page therefore expects the old contents.

// File: rtl/tlb_fa_pkg.sv
package tlb_fa_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
    logic dirty;
  } perm_t;

  localparam int REPL_ROTATE = 0;
  localparam int REPL_RANDOM = 1;

endpackage

// File: rtl/tlb_fa_match.sv
module tlb_fa_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] slot_used,
  input  logic [VPN_W-1:0]   slot_tag [ENTRIES],
  input  logic [VPN_W-1:0]   key,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [IDX_W-1:0]   hit_idx
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = slot_used[g] && (slot_tag[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_fa_victim.sv
module tlb_fa_victim #(
  parameter int ENTRIES = 16,
  parameter int REPL    = 0,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] slot_used,
  input  logic               dup_any,
  input  logic [IDX_W-1:0]   dup_idx,
  input  logic               advance,
  output logic [IDX_W-1:0]   victim
);

  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] repl_idx;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!slot_used[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  if (REPL == tlb_fa_pkg::REPL_RANDOM) begin : g_random
    logic [15:0] lfsr;
    always_ff @(posedge clk) begin
      if (!rst_n) lfsr <= 16'hACE1;
      else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    assign repl_idx = IDX_W'(lfsr % 16'(ENTRIES));
  end else begin : g_rotate
    logic [IDX_W-1:0] ptr;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptr <= '0;
      end else if (advance) begin
        if (ptr == IDX_W'(ENTRIES - 1)) ptr <= '0;
        else                            ptr <= ptr + 1'b1;
      end
    end
    assign repl_idx = ptr;
  end

  always_comb begin
    if (dup_any)       victim = dup_idx;
    else if (free_any) victim = free_idx;
    else               victim = repl_idx;
  end

endmodule

// File: rtl/tlb_fa_perm.sv
module tlb_fa_perm
  import tlb_fa_pkg::*;
(
  input  acc_e  acc,
  input  perm_t perm,
  output logic  deny,
  output logic  need_dirty
);

  always_comb begin
    deny       = 1'b0;
    need_dirty = 1'b0;
    unique case (acc)
      ACC_LOAD:  deny = !perm.rd;
      ACC_STORE: begin
        deny       = !perm.wr;
        need_dirty = perm.wr && !perm.dirty;
      end
      ACC_FETCH: deny = !perm.ex;
      default:   deny = 1'b1;
    endcase
  end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_fa_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int REPL    = REPL_ROTATE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [1:0]             lk_acc,
  input  logic [VPN_W+OFF_W-1:0] lk_vaddr,
  output logic                   lk_hit,
  output logic                   lk_miss,
  output logic                   lk_fault,
  output logic                   lk_dirty,
  output logic [PPN_W+OFF_W-1:0] lk_paddr,
  input  logic                   fill_valid,
  output logic                   fill_ready,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic                   fill_r,
  input  logic                   fill_w,
  input  logic                   fill_x,
  input  logic                   fill_d,
  input  logic                   flush
);

  localparam int VA_W  = VPN_W + OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ent_v;
  logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn  [ENTRIES];
  perm_t              ent_perm [ENTRIES];

  logic [VPN_W-1:0]   lk_vpn;
  logic [OFF_W-1:0]   lk_off;
  logic [ENTRIES-1:0] lk_hvec;
  logic [IDX_W-1:0]   lk_idx;
  logic               lk_any;
  logic               lk_deny;
  logic               lk_need_d;

  logic [ENTRIES-1:0] fd_hvec;
  logic [IDX_W-1:0]   fd_idx;
  logic               fd_any;
  logic               fill_go;
  logic [IDX_W-1:0]   vic_idx;

  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
  assign lk_off = lk_vaddr[OFF_W-1:0];

  tlb_fa_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
    .slot_used (ent_v),
    .slot_tag  (ent_vpn),
    .key       (lk_vpn),
    .hit_vec   (lk_hvec),
    .hit_idx   (lk_idx)
  );

  tlb_fa_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_match (
    .slot_used (ent_v),
    .slot_tag  (ent_vpn),
    .key       (fill_vpn),
    .hit_vec   (fd_hvec),
    .hit_idx   (fd_idx)
  );

  assign lk_any = |lk_hvec;
  assign fd_any = |fd_hvec;

  tlb_fa_perm u_perm (
    .acc        (acc_e'(lk_acc)),
    .perm       (ent_perm[lk_idx]),
    .deny       (lk_deny),
    .need_dirty (lk_need_d)
  );

  always_comb begin
    lk_hit   = lk_valid && lk_any && !lk_deny && !lk_need_d;
    lk_miss  = lk_valid && !lk_any;
    lk_fault = lk_valid && lk_any && lk_deny;
    lk_dirty = lk_valid && lk_any && !lk_deny && lk_need_d;
    lk_paddr = lk_hit ? {ent_ppn[lk_idx], lk_off} : '0;
  end

  assign fill_ready = !flush;
  assign fill_go    = fill_valid && fill_ready;

  tlb_fa_victim #(.ENTRIES(ENTRIES), .REPL(REPL)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_used (ent_v),
    .dup_any   (fd_any),
    .dup_idx   (fd_idx),
    .advance   (fill_go),
    .victim    (vic_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ent_v <= '0;
    else if (flush)   ent_v <= '0;
    else if (fill_go) ent_v[vic_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      ent_vpn[vic_idx]  <= fill_vpn;
      ent_ppn[vic_idx]  <= fill_ppn;
      ent_perm[vic_idx] <= '{rd: fill_r, wr: fill_w, ex: fill_x, dirty: fill_d};
    end
  end

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lk_valid,
  input logic [VPN_W+OFF_W-1:0] lk_vaddr,
  input logic                   lk_hit,
  input logic                   lk_miss,
  input logic                   lk_fault,
  input logic                   lk_dirty,
  input logic [PPN_W+OFF_W-1:0] lk_paddr,
  input logic                   fill_valid,
  input logic                   fill_ready,
  input logic [VPN_W-1:0]       fill_vpn,
  input logic                   flush,
  input logic [ENTRIES-1:0]     lk_hvec
);

  // R6: one outcome per lookup, none otherwise
  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lk_hit, lk_miss, lk_fault, lk_dirty}) == (lk_valid ? 1 : 0));

  // R2: page offset passes through unchanged
  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

  // R8: never two entries carrying the same tag
  p_no_dup_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hvec));

  // R11: lookups right after a flush find nothing
  p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush) && lk_valid) |-> lk_miss);

  // R11: no refill accepted during a flush
  p_flush_stalls_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fill_ready);

  // R7: an accepted refill is present next cycle
  p_fill_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_valid && fill_ready) && lk_valid &&
     lk_vaddr[VPN_W+OFF_W-1:OFF_W] == $past(fill_vpn)) |-> !lk_miss);

  // R3: absent lookups carry no address
  p_miss_zero_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> lk_paddr == '0);

endmodule

bind tlb_fa tlb_fa_chk #(
  .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_dirty(lk_dirty),
  .lk_paddr(lk_paddr), .fill_valid(fill_valid), .fill_ready(fill_ready),
  .fill_vpn(fill_vpn), .flush(flush), .lk_hvec(lk_hvec)
);

// File: tb/tlb_fa_test.sv
module tlb_fa_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        lk_valid = 0;
  logic [1:0]  lk_acc = 0;
  logic [31:0] lk_vaddr = 0;
  logic        lk_hit, lk_miss, lk_fault, lk_dirty, fill_ready;
  logic [31:0] lk_paddr;
  logic        fill_valid = 0;
  logic [19:0] fill_vpn = 0, fill_ppn = 0;
  logic        fill_r = 0, fill_w = 0, fill_x = 0, fill_d = 0;
  logic        flush = 0;

  int checks = 0, failures = 0;

  // reference model state
  bit          m_v [N];
  logic [19:0] m_vpn [N];
  logic [19:0] m_ppn [N];
  bit          m_r [N], m_w [N], m_x [N], m_d [N];
  int          m_ptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_fa #(.ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_acc(lk_acc),
    .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_fault(lk_fault), .lk_dirty(lk_dirty), .lk_paddr(lk_paddr),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_r(fill_r), .fill_w(fill_w), .fill_x(fill_x),
    .fill_d(fill_d), .flush(flush)
  );

  task automatic compare(input string tag);
    int   idx = -1;
    bit   eh = 0, em = 0, ef = 0, ed = 0;
    logic [31:0] epa = 0;
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == lk_vaddr[31:12]) idx = i;
    if (lk_valid) begin
      if (idx < 0) em = 1;
      else begin
        bit ok;
        case (lk_acc)
          2'd0: ok = m_r[idx];
          2'd1: ok = m_w[idx];
          2'd2: ok = m_x[idx];
          default: ok = 0;
        endcase
        if (!ok) ef = 1;
        else if (lk_acc == 2'd1 && !m_d[idx]) ed = 1;
        else begin eh = 1; epa = {m_ppn[idx], lk_vaddr[11:0]}; end
      end
    end
    checks++;
    if ({lk_hit, lk_miss, lk_fault, lk_dirty} !== {eh, em, ef, ed} ||
        lk_paddr !== epa || fill_ready !== !flush) begin
      failures++;
      $display("FAIL %s: hit/miss/fault/dirty=%b paddr=%h rdy=%b expected %b paddr=%h rdy=%b",
               tag, {lk_hit, lk_miss, lk_fault, lk_dirty}, lk_paddr, fill_ready,
               {eh, em, ef, ed}, epa, !flush);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
      m_ptr = 0;
    end else if (flush) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else if (fill_valid) begin
      int t = -1;
      for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == fill_vpn) t = i;
      if (t < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) t = i;
      if (t < 0) t = m_ptr;
      m_v[t] = 1; m_vpn[t] = fill_vpn; m_ppn[t] = fill_ppn;
      m_r[t] = fill_r; m_w[t] = fill_w; m_x[t] = fill_x; m_d[t] = fill_d;
      m_ptr = (m_ptr + 1) % N;
    end
  endtask

  // one clock: inputs already set after falling edge
  task automatic cyc(input string tag);
    #1 compare(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    lk_valid = 0; fill_valid = 0; flush = 0;
  endtask

  task automatic look(input string tag, input logic [1:0] acc, input logic [31:0] va);
    lk_valid = 1; lk_acc = acc; lk_vaddr = va;
    cyc(tag);
  endtask

  task automatic fill(input string tag, input logic [19:0] vpn, input logic [19:0] ppn,
                      input bit r, input bit w, input bit x, input bit d);
    fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn;
    fill_r = r; fill_w = w; fill_x = x; fill_d = d;
    cyc(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) begin @(posedge clk); model_edge(); @(negedge clk); end
    rst_n = 1;
    look("R1", 2'd0, 32'h12345678);
    cyc("R6");                                   // idle: no outcome flags
    fill("R7", 20'h00010, 20'hABCDE, 1, 1, 1, 1);
    look("R2", 2'd0, 32'h00010123);
    look("R2", 2'd1, 32'h00010FFF);
    look("R2", 2'd2, 32'h00010000);
    look("R3", 2'd0, 32'h00011123);
    fill("R4", 20'h00020, 20'h11111, 1, 0, 0, 0);
    look("R4", 2'd1, 32'h00020004);
    look("R4", 2'd2, 32'h00020008);
    look("R4", 2'd3, 32'h0002000C);
    look("R4", 2'd0, 32'h00020010);
    fill("R5", 20'h00030, 20'h22222, 1, 1, 0, 0);
    look("R5", 2'd1, 32'h00030444);
    look("R5", 2'd0, 32'h00030444);
    fill("R8", 20'h00030, 20'h33333, 1, 1, 0, 1);
    look("R8", 2'd1, 32'h00030444);
    fill("R9", 20'h00040, 20'h44444, 1, 1, 1, 1);
    // same-cycle refill and lookup of one page sees old contents
    fill_valid = 1; fill_vpn = 20'h00050; fill_ppn = 20'h55555;
    fill_r = 1; fill_w = 1; fill_x = 1; fill_d = 1;
    lk_valid = 1; lk_acc = 2'd0; lk_vaddr = 32'h00050001;
    cyc("R7");
    look("R10", 2'd0, 32'h00020010);
    look("R10", 2'd0, 32'h00050001);
    look("R10", 2'd0, 32'h00010001);
    look("R10", 2'd0, 32'h00040001);
    // flush with a refill offered in the same cycle
    flush = 1; fill_valid = 1; fill_vpn = 20'h00060; fill_ppn = 20'h66666;
    lk_valid = 1; lk_acc = 2'd0; lk_vaddr = 32'h00010001;
    cyc("R11");
    look("R11", 2'd0, 32'h00010001);
    look("R11", 2'd0, 32'h00060001);
    fill("R9", 20'h00100, 20'h0A000, 1, 0, 1, 0);
    fill("R9", 20'h00200, 20'h0B000, 1, 0, 1, 0);
    fill("R9", 20'h00300, 20'h0C000, 1, 0, 1, 0);
    fill("R9", 20'h00400, 20'h0D000, 1, 0, 1, 0);
    fill("R10", 20'h00500, 20'h0E000, 1, 1, 1, 1);
    for (int k = 1; k <= 5; k++) look("R10", 2'd2, {20'(k * 'h100), 12'h0AB});
    fill("R10", 20'h00600, 20'h0F000, 1, 1, 1, 1);
    for (int k = 1; k <= 6; k++) look("R10", 2'd0, {20'(k * 'h100), 12'h321});
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule